// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM built as 262,144 words of 16 bits, with one enable per byte lane. The host raises a request with a direction, an 18-bit word address, write data and a byte mask. The sequencer then produces the active-low chip select, write enable, output enable and byte enables on the memory side, holds the address, and drives or releases the data bus through a drive-enable signal. When the access is done it pulses `ready` for one clock. On a read, `rdata` carries the captured word during that pulse.

Every phase length is a count of system clocks. The count is worked out at elaboration from a minimum time in nanoseconds and the clock period parameter, rounded up, and never less than one cycle. A write runs through three phases: a setup phase with write enable high, a write-enable pulse, and a closing phase with write enable high again. Across all three, chip select, the address, the byte enables and the bus data do not change. A read is one access phase with output enable low. When a write follows a read, a turnaround gap is placed ahead of it. A request whose byte mask is all zeros completes at once and toggles no strobe.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are high, both byte enables are high, the bus drive enable is low and `ready` is low.
- R2: A write whose mask is non-zero holds chip select low for SU+WP+END cycles (1+2+1 at the defaults) and write enable low for WP cycles, inside that window. The bus is driven with unchanging data for the whole window. `ready` goes high 5 clock edges after the edge on which the request is accepted from idle, counting that edge as the first.
- R3: A read holds chip select and output enable low, with write enable high, for RD = max(address access, output-enable access, cycle time) cycles (3 at the defaults). The bus is not driven during the read. `ready` goes high on the 4th edge counted from acceptance, and `rdata` is valid while `ready` is high.
- R4: Mask bit 0 selects the lower lane (data bits 7:0, byte enable bit 0) and mask bit 1 selects the upper lane (bits 15:8, byte enable bit 1). A write with one mask bit set pulls only that lane's enable low, so the other byte in memory is left as it was.
- R5: On a read, a lane whose mask bit is clear returns zero in `rdata`.
- R6: The memory address does not change while chip select and write enable are both low.
- R7: The bus drive enable and output enable are never active in the same cycle.
- R8: When a write follows a read, output enable stays high for at least 2+TA cycles before the bus is driven (3 at the defaults). A write issued back to back after a read takes exactly one cycle longer than a write issued back to back after a write.
- R9: A request with mask 00 makes `ready` go high on the first edge after acceptance. It asserts no strobe and leaves the memory contents unchanged.
- R10: `ready` stays high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request; sampled only when the sequencer is idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask; bit 0 lower lane, bit 1 upper lane |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid while ready is high after a read |
| sram_addr | output | 18 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Byte enables, active low; bit 0 lower, bit 1 upper |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from memory |

## Verification
The hardest case to reach is a write that arrives in the cycle just after a read finishes, because that is the only path that goes through the turnaround gap. The bench reaches it by issuing the write request at the same sample point where it sees the read's `ready` pulse. It then measures how many cycles pass between output enable rising and the bus drive turning on, and compares that latency against a write issued back to back after another write. Single-lane writes followed by full and partial reads show that an unselected byte is neither written nor returned.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WEND,
        ST_RACC,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
        logic ready;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                        drive: 1'b0, ready: 1'b0};

    // ceiling of ns / clk_ns, at least one cycle
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // cycles still needed once have_ns already elapsed, at least one
    function automatic int rest_cyc(input int need_ns, input int have_ns, input int clk_ns);
        if (need_ns <= have_ns) return 1;
        return ns_to_cyc(need_ns - have_ns, clk_ns);
    endfunction

    // counts still needed once have cycles are spent, at least one
    function automatic int rest_cnt(input int need, input int have);
        return max_int(1, need - have);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic [DATA_W-1:0] dq_i,
    output logic [LANES-1:0]  mask_nx,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [LANES-1:0] mask_q;

    assign mask_nx = accept ? req_mask : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            mask_q  <= req_mask;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_q[g*8 +: 8] <= '0;
            end else if (capture) begin
                rdata_q[g*8 +: 8] <= mask_q[g] ? dq_i[g*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int LANES = 2,
    parameter int SU_C  = 1,
    parameter int WP_C  = 2,
    parameter int END_C = 1,
    parameter int RD_C  = 3,
    parameter int TA_C  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_we,
    input  logic [LANES-1:0] req_mask,
    input  logic [LANES-1:0] mask_nx,
    input  logic             last,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [LANES-1:0] be_n,
    output logic             dq_oe,
    output logic             ready
);

    localparam logic [CNT_W-1:0] SU_LD  = CNT_W'(SU_C - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_C - 1);
    localparam logic [CNT_W-1:0] END_LD = CNT_W'(END_C - 1);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_C - 1);
    localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_C - 1);

    seq_state_e       state_q, state_d;
    logic             rd_flag_q, rd_flag_d;
    strobe_t          strb_q, strb_d;
    logic [LANES-1:0] be_q, be_d;

    assign accept  = (state_q == ST_IDLE) && req;
    assign capture = (state_q == ST_RACC) && last;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_mask == '0) begin
                        state_d = ST_DONE;
                    end else if (req_we) begin
                        load = 1'b1;
                        if (rd_flag_q) begin
                            state_d  = ST_TURN;
                            load_val = TA_LD;
                        end else begin
                            state_d  = ST_WSETUP;
                            load_val = SU_LD;
                        end
                    end else begin
                        state_d  = ST_RACC;
                        load     = 1'b1;
                        load_val = RD_LD;
                    end
                end
            end
            ST_TURN: begin
                if (last) begin
                    state_d  = ST_WSETUP;
                    load     = 1'b1;
                    load_val = SU_LD;
                end
            end
            ST_WSETUP: begin
                if (last) begin
                    state_d  = ST_WPULSE;
                    load     = 1'b1;
                    load_val = WP_LD;
                end
            end
            ST_WPULSE: begin
                if (last) begin
                    state_d  = ST_WEND;
                    load     = 1'b1;
                    load_val = END_LD;
                end
            end
            ST_WEND: begin
                if (last) state_d = ST_DONE;
            end
            ST_RACC: begin
                if (last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_flag_d = rd_flag_q;
        if (capture) begin
            rd_flag_d = 1'b1;
        end else if (state_d == ST_WSETUP) begin
            rd_flag_d = 1'b0;
        end
    end

    // strobes decoded from the next state and registered, so pins are glitch free
    always_comb begin
        strb_d = STROBE_REST;
        be_d   = '1;
        case (state_d)
            ST_WSETUP, ST_WEND: begin
                strb_d.cs_n  = 1'b0;
                strb_d.drive = 1'b1;
                be_d         = ~mask_nx;
            end
            ST_WPULSE: begin
                strb_d.cs_n  = 1'b0;
                strb_d.we_n  = 1'b0;
                strb_d.drive = 1'b1;
                be_d         = ~mask_nx;
            end
            ST_RACC: begin
                strb_d.cs_n = 1'b0;
                strb_d.oe_n = 1'b0;
                be_d        = ~mask_nx;
            end
            ST_DONE: strb_d.ready = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rd_flag_q <= 1'b0;
            strb_q    <= STROBE_REST;
            be_q      <= '1;
        end else begin
            state_q   <= state_d;
            rd_flag_q <= rd_flag_d;
            strb_q    <= strb_d;
            be_q      <= be_d;
        end
    end

    assign cs_n  = strb_q.cs_n;
    assign we_n  = strb_q.we_n;
    assign oe_n  = strb_q.oe_n;
    assign dq_oe = strb_q.drive;
    assign ready = strb_q.ready;
    assign be_n  = be_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 20,
    parameter int T_CYCLE_NS = 55,
    parameter int T_WP_NS    = 35,
    parameter int T_DW_NS    = 25,
    parameter int T_AW_NS    = 40,
    parameter int T_AA_NS    = 55,
    parameter int T_OE_NS    = 25,
    parameter int T_HZ_NS    = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  ready,
    output logic [DATA_W-1:0]     rdata,
    output logic [ADDR_W-1:0]     sram_addr,
    output logic                  sram_cs_n,
    output logic                  sram_we_n,
    output logic                  sram_oe_n,
    output logic [DATA_W/8-1:0]   sram_be_n,
    output logic [DATA_W-1:0]     sram_dq_o,
    output logic                  sram_dq_oe,
    input  logic [DATA_W-1:0]     sram_dq_i
);

    localparam int LANES = DATA_W / 8;
    localparam int RC_C  = ns_to_cyc(T_CYCLE_NS, CLK_NS);
    localparam int WP_C  = max_int(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int SU_C  = rest_cyc(T_AW_NS, WP_C * CLK_NS, CLK_NS);
    localparam int END_C = rest_cnt(RC_C, SU_C + WP_C);
    localparam int RD_C  = max_int(RC_C, max_int(ns_to_cyc(T_AA_NS, CLK_NS),
                                                 ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int TA_C  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int MAX_C = max_int(max_int(max_int(SU_C, WP_C), max_int(END_C, RD_C)), TA_C);
    localparam int CNT_W = max_int(1, $clog2(MAX_C + 1));

    logic             t_load;
    logic [CNT_W-1:0] t_load_val;
    logic             t_last;
    logic             accept;
    logic             capture;
    logic [LANES-1:0] mask_nx;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_load_val),
        .last     (t_last)
    );

    sram_req_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .dq_i      (sram_dq_i),
        .mask_nx   (mask_nx),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_o),
        .rdata_q   (rdata)
    );

    sram_seq_fsm #(
        .CNT_W (CNT_W),
        .LANES (LANES),
        .SU_C  (SU_C),
        .WP_C  (WP_C),
        .END_C (END_C),
        .RD_C  (RD_C),
        .TA_C  (TA_C)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_we   (req_we),
        .req_mask (req_mask),
        .mask_nx  (mask_nx),
        .last     (t_last),
        .load     (t_load),
        .load_val (t_load_val),
        .accept   (accept),
        .capture  (capture),
        .cs_n     (sram_cs_n),
        .we_n     (sram_we_n),
        .oe_n     (sram_oe_n),
        .be_n     (sram_be_n),
        .dq_oe    (sram_dq_oe),
        .ready    (ready)
    );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                ready,
    input logic [ADDR_W-1:0]   sram_addr,
    input logic                sram_cs_n,
    input logic                sram_we_n,
    input logic                sram_oe_n,
    input logic [DATA_W/8-1:0] sram_be_n,
    input logic [DATA_W-1:0]   sram_dq_o,
    input logic                sram_dq_oe
);

    a_r2_write_frame: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_cs_n && sram_dq_oe && (sram_be_n != '1)));

    a_r2_data_stable: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> $stable(sram_dq_o));

    a_r3_read_frame: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (sram_we_n && !sram_cs_n));

    a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && !sram_cs_n) |-> $stable(sram_addr));

    a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> ($past(sram_oe_n) && $past(sram_oe_n, 2)));

    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_be_n  (sram_be_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        ready;
    logic [15:0] rdata;
    logic [17:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_strobe_ctrl u_sram_strobe_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .ready      (ready),
        .rdata      (rdata),
        .sram_addr  (sram_addr),
        .sram_cs_n  (sram_cs_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_be_n  (sram_be_n),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe),
        .sram_dq_i  (sram_dq_i)
    );

    // memory model: 256 words, indexed by low address bits
    logic [15:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

    always @(posedge sram_we_n) begin
        if (!sram_cs_n) begin
            if (!sram_be_n[0]) mem[sram_addr[7:0]][7:0]  = sram_dq_o[7:0];
            if (!sram_be_n[1]) mem[sram_addr[7:0]][15:8] = sram_dq_o[15:8];
        end
    end

    wire rd_on = !sram_cs_n && !sram_oe_n && sram_we_n;
    assign sram_dq_i[7:0]  = (rd_on && !sram_be_n[0]) ? mem[sram_addr[7:0]][7:0]  : 8'hEE;
    assign sram_dq_i[15:8] = (rd_on && !sram_be_n[1]) ? mem[sram_addr[7:0]][15:8] : 8'hEE;

    // port monitor, sampled away from the active edge
    int          n_cs = 0, n_we = 0, n_oe = 0, n_drv = 0, n_rdy = 0;
    int          v_addr = 0, v_bus = 0, oe_gap = 100, gap_at_drive = 0;
    logic [1:0]  be_at_we = 2'b11;
    logic [17:0] prev_addr = '0;
    logic        prev_drv = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_cs_n) n_cs++;
            if (!sram_we_n) begin n_we++; be_at_we = sram_be_n; end
            if (!sram_oe_n) n_oe++;
            if (sram_dq_oe) n_drv++;
            if (ready) n_rdy++;
            if (!sram_cs_n && !sram_we_n && sram_addr != prev_addr) v_addr++;
            if (sram_dq_oe && !sram_oe_n) v_bus++;
            if (sram_dq_oe && !prev_drv) gap_at_drive = oe_gap;
            oe_gap = !sram_oe_n ? 0 : oe_gap + 1;
        end
        prev_drv  = sram_dq_oe;
        prev_addr = sram_addr;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic op(input logic we, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] m, output int lat);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ready && lat < 50);
        req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cs_n", sram_cs_n, 1);
        chk("R1 we_n", sram_we_n, 1);
        chk("R1 oe_n", sram_oe_n, 1);
        chk("R1 be_n", sram_be_n, 2'b11);
        chk("R1 dq_oe", sram_dq_oe, 0);
        chk("R1 ready", ready, 0);
    endtask

    task automatic t_word();
        int lat, c0, w0, o0, d0, r0;
        idle(2);
        c0 = n_cs; w0 = n_we; d0 = n_drv; r0 = n_rdy;
        op(1'b1, 18'h00012, 16'h1234, 2'b11, lat);
        idle(1);
        chk("R2 write latency", lat, 5);
        chk("R2 cs low cycles", n_cs - c0, 4);
        chk("R2 we low cycles", n_we - w0, 2);
        chk("R2 drive cycles", n_drv - d0, 4);
        chk("R10 ready cycles write", n_rdy - r0, 1);
        idle(2);
        o0 = n_oe; d0 = n_drv; r0 = n_rdy;
        op(1'b0, 18'h00012, 16'h0000, 2'b11, lat);
        chk("R3 read data", rdata, 16'h1234);
        idle(1);
        chk("R3 read latency", lat, 4);
        chk("R3 oe low cycles", n_oe - o0, 3);
        chk("R3 no drive on read", n_drv - d0, 0);
        chk("R10 ready cycles read", n_rdy - r0, 1);
    endtask

    task automatic t_lanes();
        int lat;
        idle(2);
        op(1'b1, 18'h00012, 16'hABCD, 2'b01, lat);
        chk("R4 lower-only byte enables", be_at_we, 2'b10);
        idle(2);
        op(1'b0, 18'h00012, 16'h0000, 2'b11, lat);
        chk("R4 upper byte kept", rdata, 16'h12CD);
        idle(2);
        op(1'b1, 18'h3FFFF, 16'h5A5A, 2'b10, lat);
        chk("R4 upper-only byte enables", be_at_we, 2'b01);
        idle(2);
        op(1'b0, 18'h00012, 16'h0000, 2'b10, lat);
        chk("R5 upper lane read", rdata, 16'h1200);
        idle(2);
        op(1'b0, 18'h00012, 16'h0000, 2'b01, lat);
        chk("R5 lower lane read", rdata, 16'h00CD);
        idle(2);
        op(1'b0, 18'h3FFFF, 16'h0000, 2'b11, lat);
        chk("R4 upper write at top address", rdata, 16'h5A00);
    endtask

    task automatic t_turn();
        int lat;
        idle(2);
        op(1'b0, 18'h00012, 16'h0000, 2'b11, lat);
        op(1'b1, 18'h00020, 16'h7777, 2'b11, lat);
        chk("R8 gap before drive", gap_at_drive, 3);
        chk("R8 write after read latency", lat, 7);
        op(1'b1, 18'h00021, 16'h8888, 2'b11, lat);
        chk("R8 write after write latency", lat, 6);
        idle(2);
        op(1'b0, 18'h00020, 16'h0000, 2'b11, lat);
        chk("R8 data after turnaround", rdata, 16'h7777);
    endtask

    task automatic t_zero();
        int lat, c0, r0;
        idle(2);
        c0 = n_cs; r0 = n_rdy;
        op(1'b1, 18'h00012, 16'hFFFF, 2'b00, lat);
        idle(1);
        chk("R9 zero-mask write latency", lat, 1);
        chk("R9 zero-mask no chip select", n_cs - c0, 0);
        chk("R10 zero-mask ready cycles", n_rdy - r0, 1);
        op(1'b0, 18'h00012, 16'h0000, 2'b00, lat);
        chk("R9 zero-mask read latency", lat, 1);
        idle(2);
        op(1'b0, 18'h00012, 16'h0000, 2'b11, lat);
        chk("R9 memory unchanged", rdata, 16'h12CD);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_word();
        t_lanes();
        t_turn();
        t_zero();
        idle(2);
        chk("R6 address moved under write strobe", v_addr, 0);
        chk("R7 bus contention cycles", v_bus, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule